// File: doc/BRIEF.md
# Processor Interrupt Acceptance and Dispatch Unit

This unit sits on the processor side of the interrupt path. Each time it is free, it picks the next interrupt to take and reports the vector number with a one-clock dispatch strobe. Four kinds of request reach it:

- an exception raised inside the processor (a divide fault, for example), which carries its own vector;
- a software interrupt instruction, which carries an 8-bit vector;
- a non-maskable request pin, which has its own external enable;
- a level request line from an external interrupt controller.

The unit holds the interrupt-enable flag. Set and clear commands change the flag. Only the controller line depends on it.

A controller request is not given a vector inside the processor. The unit runs an acknowledge handshake of two pulses and takes the vector byte from the data bus during the second pulse. The other three sources dispatch one clock after they are chosen. After every strobe the unit waits for a ready input before it can start another dispatch. The consumer uses this to pace handler entry.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, `disp_o` and `ack_o` are low and the interrupt-enable flag `ie_o` is clear.
- R2: While `ie_o` is low, a high `mreq_i` produces no acknowledge pulse and no dispatch.
- R3: While idle with `ie_o` high, a high `mreq_i` starts the handshake. `ack_o` is high for exactly one clock in the next cycle, low for one clock, then high for one more clock.
- R4: The byte on `bus_i` during the second acknowledge pulse is captured. It appears on `disp_vec_o` with `disp_o` high in the clock after that pulse.
- R5: A software interrupt request dispatches with `swi_vec_i` one clock after it is seen while idle, whatever the value of `ie_o`.
- R6: An exception request dispatches with `exc_vec_i` one clock after it is seen while idle, whatever the value of `ie_o`, and it never causes an acknowledge pulse.
- R7: A rising edge on `nmi_i` while `nmi_en_i` is high yields exactly one dispatch with vector 2, even if the pin stays high. `ie_o` has no effect on it.
- R8: A rising edge on `nmi_i` while `nmi_en_i` is low is dropped and never dispatches.
- R9: When several requests are pending at once, the exception goes first, then the software interrupt, then the non-maskable request, then the controller line.
- R10: Every dispatch clears `ie_o`, so it is low in the strobe cycle. `ie_set_i` sets the flag and `ie_clr_i` clears it. When both are high together, the clear wins.
- R11: `disp_o` is high for a single clock. After a strobe, no new dispatch starts until `ready_i` has been high for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_i | input | 1 | Level request from the interrupt controller |
| bus_i | input | 8 | Data bus, vector byte during second acknowledge |
| ack_o | output | 1 | Acknowledge pulse to the interrupt controller |
| nmi_i | input | 1 | Non-maskable request pin, edge sensitive |
| nmi_en_i | input | 1 | External enable for the non-maskable pin |
| exc_req_i | input | 1 | Internal exception request |
| exc_vec_i | input | 8 | Vector of the internal exception |
| swi_req_i | input | 1 | Software interrupt request |
| swi_vec_i | input | 8 | Vector of the software interrupt |
| ie_set_i | input | 1 | Command that sets the interrupt-enable flag |
| ie_clr_i | input | 1 | Command that clears the interrupt-enable flag |
| ready_i | input | 1 | Consumer can accept the next dispatch |
| disp_o | output | 1 | One-clock dispatch strobe |
| disp_vec_o | output | 8 | Vector number valid with `disp_o` |
| ie_o | output | 1 | Current interrupt-enable flag |

## Verification
A corrupted sequencer state shows at the ports within one or two clocks. Possible symptoms are an acknowledge pulse that lasts longer than a clock, a second pulse that is missing, or a strobe that does not follow the second pulse. A wrong pending bit for the non-maskable request shows as a missing vector-2 strobe or a repeated one within two clocks of the edge. A wrong enable flag shows as an acknowledge pulse that should not happen, or one that never comes, in the clock after the controller line is seen. A wrong arbitration order shows in the first strobe after simultaneous requests.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned NSRC    = 4;
  localparam int unsigned SRC_EXC = 0;
  localparam int unsigned SRC_SWI = 1;
  localparam int unsigned SRC_NMI = 2;
  localparam int unsigned SRC_MSK = 3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACK1 = 3'd1,
    ST_GAP  = 3'd2,
    ST_ACK2 = 3'd3,
    ST_WAIT = 3'd4
  } irqd_state_e;
endpackage

// File: rtl/irqd_nmi_edge.sv
module irqd_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic en_i,
  input  logic take_i,
  output logic pend_o
);
  logic pin_q;
  logic pend_q;
  logic pend_d;
  logic rise;

  assign rise = pin_i & ~pin_q;

  always_comb begin
    pend_d = pend_q;
    if (take_i)        pend_d = 1'b0;
    if (rise && en_i)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pin_q  <= pin_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irqd_ie_flag.sv
module irqd_ie_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic disp_i,
  output logic ie_o
);
  logic ie_q;
  logic ie_d;

  always_comb begin
    ie_d = ie_q;
    if (set_i)  ie_d = 1'b1;
    if (clr_i)  ie_d = 1'b0;
    if (disp_i) ie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie_q <= 1'b0;
    else        ie_q <= ie_d;
  end

  assign ie_o = ie_q;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int unsigned VW      = 8,
  parameter int unsigned NMI_VEC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mreq_i,
  input  logic [VW-1:0] bus_i,
  output logic          ack_o,
  input  logic          nmi_i,
  input  logic          nmi_en_i,
  input  logic          exc_req_i,
  input  logic [VW-1:0] exc_vec_i,
  input  logic          swi_req_i,
  input  logic [VW-1:0] swi_vec_i,
  input  logic          ie_set_i,
  input  logic          ie_clr_i,
  input  logic          ready_i,
  output logic          disp_o,
  output logic [VW-1:0] disp_vec_o,
  output logic          ie_o
);
  import irqd_pkg::*;

  localparam logic [VW-1:0] NMI_VEC_W = VW'(NMI_VEC);

  irqd_state_e     state_q, state_d;
  logic            disp_q, disp_d;
  logic [VW-1:0]   vec_q, vec_d;
  logic            vec_en;
  logic            idle;
  logic            nmi_pend;
  logic            nmi_take;
  logic            ie;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] gnt;
  logic            any;

  assign idle = (state_q == ST_IDLE);

  irqd_nmi_edge u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (nmi_i),
    .en_i   (nmi_en_i),
    .take_i (nmi_take),
    .pend_o (nmi_pend)
  );

  always_comb begin
    req          = '0;
    req[SRC_EXC] = idle & exc_req_i;
    req[SRC_SWI] = idle & swi_req_i;
    req[SRC_NMI] = idle & nmi_pend;
    req[SRC_MSK] = idle & mreq_i & ie;
  end

  irqd_arbiter #(.N(NSRC)) u_arb (
    .req_i (req),
    .gnt_o (gnt),
    .any_o (any)
  );

  assign nmi_take = gnt[SRC_NMI];

  irqd_ie_flag u_ie (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ie_set_i),
    .clr_i  (ie_clr_i),
    .disp_i (disp_d),
    .ie_o   (ie)
  );

  always_comb begin
    state_d = state_q;
    disp_d  = 1'b0;
    vec_d   = vec_q;
    vec_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (any) begin
          if (gnt[SRC_MSK]) begin
            state_d = ST_ACK1;
          end else begin
            disp_d  = 1'b1;
            vec_en  = 1'b1;
            state_d = ST_WAIT;
            if (gnt[SRC_EXC])      vec_d = exc_vec_i;
            else if (gnt[SRC_SWI]) vec_d = swi_vec_i;
            else                   vec_d = NMI_VEC_W;
          end
        end
      end
      ST_ACK1: state_d = ST_GAP;
      ST_GAP:  state_d = ST_ACK2;
      ST_ACK2: begin
        disp_d  = 1'b1;
        vec_en  = 1'b1;
        vec_d   = bus_i;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (ready_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      disp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      disp_q  <= disp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign ack_o      = (state_q == ST_ACK1) || (state_q == ST_ACK2);
  assign disp_o     = disp_q;
  assign disp_vec_o = vec_q;
  assign ie_o       = ie;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int unsigned VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_o,
  input logic          disp_o,
  input logic [VW-1:0] disp_vec_o,
  input logic [VW-1:0] bus_i,
  input logic          ie_o,
  input logic          ready_i
);
  logic ack_d1;
  logic ack_d2;
  logic owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d1 <= 1'b0;
      ack_d2 <= 1'b0;
      owed   <= 1'b0;
    end else begin
      ack_d1 <= ack_o;
      ack_d2 <= ack_d1;
      if (disp_o)       owed <= ~ready_i;
      else if (ready_i) owed <= 1'b0;
    end
  end

  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  p_ack_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_d2) |=> (!ack_o ##1 ack_o));

  p_ack_needs_ie_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_d2) |-> $past(ie_o));

  p_vec_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && ack_d2) |=> (disp_o && disp_vec_o == $past(bus_i)));

  p_disp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    disp_o |=> !disp_o);

  p_wait_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    disp_o |-> !owed);

  p_disp_clears_ie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_o |-> !ie_o);
endmodule

bind irq_dispatch irqd_checker #(.VW(VW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_o      (ack_o),
  .disp_o     (disp_o),
  .disp_vec_o (disp_vec_o),
  .bus_i      (bus_i),
  .ie_o       (ie_o),
  .ready_i    (ready_i)
);

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  logic       clk;
  logic       rst_n;
  logic       mreq_i;
  logic [7:0] bus_i;
  logic       ack_o;
  logic       nmi_i;
  logic       nmi_en_i;
  logic       exc_req_i;
  logic [7:0] exc_vec_i;
  logic       swi_req_i;
  logic [7:0] swi_vec_i;
  logic       ie_set_i;
  logic       ie_clr_i;
  logic       ready_i;
  logic       disp_o;
  logic [7:0] disp_vec_o;
  logic       ie_o;

  int total;
  int bad;

  irq_dispatch u_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .mreq_i(mreq_i), .bus_i(bus_i), .ack_o(ack_o),
    .nmi_i(nmi_i), .nmi_en_i(nmi_en_i), .exc_req_i(exc_req_i),
    .exc_vec_i(exc_vec_i), .swi_req_i(swi_req_i), .swi_vec_i(swi_vec_i),
    .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .ready_i(ready_i),
    .disp_o(disp_o), .disp_vec_o(disp_vec_o), .ie_o(ie_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_ie();
    ie_set_i = 1'b1;
    tick();
    ie_set_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "disp after reset", int'(disp_o), 0);
    chk("R1", "ack after reset", int'(ack_o), 0);
    chk("R1", "ie after reset", int'(ie_o), 0);
  endtask

  task automatic t_mask_blocked();
    int acks = 0;
    int disps = 0;
    mreq_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      acks += int'(ack_o);
      disps += int'(disp_o);
    end
    mreq_i = 1'b0;
    chk("R2", "acks with ie clear", acks, 0);
    chk("R2", "dispatches with ie clear", disps, 0);
    tick();
  endtask

  task automatic t_swi();
    swi_vec_i = 8'h21;
    swi_req_i = 1'b1;
    tick();
    chk("R5", "swi strobe ie=0", int'(disp_o), 1);
    chk("R5", "swi vector ie=0", int'(disp_vec_o), 8'h21);
    swi_req_i = 1'b0;
    tick();
    chk("R11", "strobe one clock", int'(disp_o), 0);
    set_ie();
    chk("R10", "set command", int'(ie_o), 1);
    swi_vec_i = 8'h80;
    swi_req_i = 1'b1;
    tick();
    chk("R5", "swi vector ie=1", int'(disp_vec_o), 8'h80);
    chk("R10", "dispatch clears ie", int'(ie_o), 0);
    swi_req_i = 1'b0;
    tick();
  endtask

  task automatic t_exc();
    int acks = 0;
    exc_vec_i = 8'h00;
    exc_req_i = 1'b1;
    tick();
    acks += int'(ack_o);
    chk("R6", "exc strobe", int'(disp_o), 1);
    chk("R6", "exc vector", int'(disp_vec_o), 0);
    exc_req_i = 1'b0;
    tick();
    acks += int'(ack_o);
    chk("R6", "exc uses no ack", acks, 0);
  endtask

  task automatic t_mask_accept();
    set_ie();
    bus_i  = 8'hEE;
    mreq_i = 1'b1;
    tick();
    chk("R3", "first ack pulse", int'(ack_o), 1);
    mreq_i = 1'b0;
    tick();
    chk("R3", "gap clock", int'(ack_o), 0);
    bus_i = 8'h70;
    tick();
    chk("R3", "second ack pulse", int'(ack_o), 1);
    chk("R4", "no strobe during ack", int'(disp_o), 0);
    tick();
    bus_i = 8'h11;
    chk("R3", "ack ends", int'(ack_o), 0);
    chk("R4", "strobe after second ack", int'(disp_o), 1);
    chk("R4", "vector from bus", int'(disp_vec_o), 8'h70);
    chk("R10", "maskable dispatch clears ie", int'(ie_o), 0);
    tick();
  endtask

  task automatic t_nmi();
    int disps = 0;
    nmi_en_i = 1'b1;
    nmi_i    = 1'b1;
    tick();
    chk("R7", "nmi not yet", int'(disp_o), 0);
    tick();
    chk("R7", "nmi strobe", int'(disp_o), 1);
    chk("R7", "nmi vector 2", int'(disp_vec_o), 2);
    for (int i = 0; i < 10; i++) begin
      tick();
      disps += int'(disp_o);
    end
    chk("R7", "held pin no repeat", disps, 0);
    nmi_i = 1'b0;
    tick();
    nmi_en_i = 1'b0;
    nmi_i    = 1'b1;
    disps    = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      disps += int'(disp_o);
    end
    chk("R8", "disabled edge dropped", disps, 0);
    nmi_i = 1'b0;
    tick();
    nmi_en_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      disps += int'(disp_o);
    end
    chk("R8", "no late dispatch after enable", disps, 0);
  endtask

  task automatic t_priority();
    int acks = 0;
    set_ie();
    exc_vec_i = 8'h06;
    swi_vec_i = 8'h21;
    bus_i     = 8'h70;
    exc_req_i = 1'b1;
    swi_req_i = 1'b1;
    nmi_i     = 1'b1;
    mreq_i    = 1'b1;
    tick();
    chk("R9", "exception first", int'(disp_vec_o), 8'h06);
    exc_req_i = 1'b0;
    tick();
    tick();
    chk("R9", "software second strobe", int'(disp_o), 1);
    chk("R9", "software second", int'(disp_vec_o), 8'h21);
    swi_req_i = 1'b0;
    tick();
    tick();
    chk("R9", "nmi third strobe", int'(disp_o), 1);
    chk("R9", "nmi third", int'(disp_vec_o), 2);
    nmi_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      acks += int'(ack_o);
    end
    chk("R10", "ie cleared blocks line", acks, 0);
    set_ie();
    tick();
    chk("R9", "maskable last", int'(ack_o), 1);
    mreq_i = 1'b0;
    tick();
    tick();
    tick();
    chk("R9", "maskable vector", int'(disp_vec_o), 8'h70);
    tick();
  endtask

  task automatic t_flag();
    set_ie();
    chk("R10", "set", int'(ie_o), 1);
    ie_clr_i = 1'b1;
    tick();
    ie_clr_i = 1'b0;
    chk("R10", "clear", int'(ie_o), 0);
    set_ie();
    ie_set_i = 1'b1;
    ie_clr_i = 1'b1;
    tick();
    ie_set_i = 1'b0;
    ie_clr_i = 1'b0;
    chk("R10", "clear wins over set", int'(ie_o), 0);
  endtask

  task automatic t_ready();
    int disps = 0;
    ready_i   = 1'b0;
    swi_vec_i = 8'h40;
    swi_req_i = 1'b1;
    tick();
    chk("R11", "first strobe", int'(disp_o), 1);
    for (int i = 0; i < 4; i++) begin
      tick();
      disps += int'(disp_o);
    end
    chk("R11", "held off without ready", disps, 0);
    ready_i = 1'b1;
    tick();
    chk("R11", "idle clock after ready", int'(disp_o), 0);
    tick();
    chk("R11", "dispatch after ready", int'(disp_o), 1);
    swi_req_i = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total     = 0;
    bad       = 0;
    rst_n     = 1'b0;
    mreq_i    = 1'b0;
    bus_i     = 8'h00;
    nmi_i     = 1'b0;
    nmi_en_i  = 1'b1;
    exc_req_i = 1'b0;
    exc_vec_i = 8'h00;
    swi_req_i = 1'b0;
    swi_vec_i = 8'h00;
    ie_set_i  = 1'b0;
    ie_clr_i  = 1'b0;
    ready_i   = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mask_blocked();
    t_swi();
    t_exc();
    t_mask_accept();
    t_nmi();
    t_priority();
    t_flag();
    t_ready();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule